// File: doc/BRIEF.md
# Processor Status Word and Interrupt Acceptance Gate

This block keeps the processor status word of a small CPU core and decides, one cycle at a time, whether a pending interrupt is taken. The status word is 16 bits wide with 11 live bits. Four of them are arithmetic flags that the ALU refreshes through a result strobe. There is also a debug bit, a register-bank bit, an interrupt-enable bit, a stack-select bit and a 3-bit processor priority level. The core can overwrite the whole word in one write.

Two kinds of request arrive. A software request carries a 6-bit vector number and is taken unconditionally. A hardware request carries a 3-bit level and is taken only when the enable bit is set and its level beats the current priority level. When a request is taken, a registered accept pulse goes high for one cycle. On the same clock edge the enable bit is cleared and, where the rules call for it, the stack-select bit is cleared as well. Fetching the vector and saving the program counter and status word on the stack belong to neighbouring logic.

Top module: `psw_irq_gate`

## Requirements
- R1: While reset is asserted and just after it, flagWord reads 0x0000, acceptPulse is 0 and stackUser is 0.
- R2: When aluStrobe is high and wrEn is low, the next flagWord takes the following values: bit 0 (carry) from aluCarry, bit 5 (overflow) from aluOverflow, bit 2 (zero) set exactly when aluResult is 0, and bit 3 (sign) from the most significant bit of aluResult. All other bits keep their values.
- R3: wrEn loads wrData into bits 0-7 and 12-14 on the next edge. Bits 8-11 and 15 always read 0. A write made in the same cycle as aluStrobe wins over the ALU update.
- R4: Each cycle with swReq high yields acceptPulse high in the following cycle, for any vector and for any enable or level setting. Without a request in that cycle, the pulse falls again.
- R5: A hardware request alone is taken only if bit 6 (enable) is 1 and hwLevel is strictly greater than the level in bits 14:12. When swReq is also high in that cycle, exactly one accept pulse results.
- R6: On every accepted request, bit 6 (enable) reads 0 in the same cycle that acceptPulse is high.
- R7: Bit 7 (stack select) is cleared along with the pulse for an accepted hardware request and for a software vector of 0 to 31. A software vector of 32 to 63 leaves it unchanged.
- R8: When a write and an acceptance fall on the same edge, bits 6 and 7 follow the acceptance rules of R6 and R7, and all other live bits take the written values.
- R9: stackUser equals bit 7 of flagWord at all times (1 selects the user stack, 0 the interrupt stack).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| aluStrobe | input | 1 | Refresh the arithmetic flags from the ALU inputs |
| aluResult | input | 16 | ALU result used for the zero and sign flags |
| aluCarry | input | 1 | Carry, borrow or shifted-out bit |
| aluOverflow | input | 1 | Signed overflow indication |
| wrEn | input | 1 | Whole-word write strobe |
| wrData | input | 16 | Status word to write |
| swReq | input | 1 | Software interrupt request |
| swVector | input | 6 | Software interrupt vector number |
| hwReq | input | 1 | Hardware interrupt request |
| hwLevel | input | 3 | Priority level of the hardware request |
| flagWord | output | 16 | Current status word |
| acceptPulse | output | 1 | One-cycle pulse for an accepted request |
| stackUser | output | 1 | Stack in use: 1 user, 0 interrupt |

## Verification
The assertions assume that the requests and ALU inputs are driven to known values from the first clock edge after reset. They also assume that a software request and its vector are valid in the same cycle. The bench holds every input at zero through reset and changes inputs only on falling edges. Each request is presented for one cycle and then withdrawn, so every accept pulse can be traced to a single request cycle. The sweeps cover all enable, level and request-level combinations and all 64 software vectors, always starting from a status word written just before.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int WORD_W  = 16;
  localparam int CARRY_B = 0;
  localparam int DEBUG_B = 1;
  localparam int ZERO_B  = 2;
  localparam int SIGN_B  = 3;
  localparam int BANK_B  = 4;
  localparam int OVF_B   = 5;
  localparam int IEN_B   = 6;
  localparam int STACK_B = 7;
  localparam int LVL_LO  = 12;
  localparam int LVL_W   = 3;
  localparam int LVL_HI  = LVL_LO + LVL_W - 1;
  localparam logic [WORD_W-1:0] LIVE_MASK = 16'h70FF;

  typedef struct packed {
    logic ldAlu;
    logic ldWord;
    logic ackTake;
    logic clrStack;
  } flagStrobe_t;
endpackage

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
#(
  parameter int VEC_W         = 6,
  parameter int LEVEL_W       = LVL_W,
  parameter int STACK_VEC_LIM = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               aluStrobe,
  input  logic               wrEn,
  input  logic               swReq,
  input  logic [VEC_W-1:0]   swVector,
  input  logic               hwReq,
  input  logic [LEVEL_W-1:0] hwLevel,
  input  logic               ieFlag,
  input  logic [LEVEL_W-1:0] curLevel,
  output flagStrobe_t        strobes,
  output logic               acceptPulse
);
  localparam int VEC_CNT = 1 << VEC_W;
  localparam logic [VEC_W:0] STACK_LIM = (STACK_VEC_LIM > VEC_CNT) ?
                                         (VEC_W+1)'(VEC_CNT) : (VEC_W+1)'(STACK_VEC_LIM);

  logic swTake;
  logic hwTake;
  logic lowVector;

  always_comb begin
    swTake    = swReq;
    hwTake    = hwReq && ieFlag && (hwLevel > curLevel) && !swReq;
    lowVector = {1'b0, swVector} < STACK_LIM;
    strobes.ldAlu    = aluStrobe;
    strobes.ldWord   = wrEn;
    strobes.ackTake  = swTake || hwTake;
    strobes.clrStack = hwTake || (swTake && lowVector);
  end

  always_ff @(posedge clk) begin
    if (!rstN) acceptPulse <= 1'b0;
    else       acceptPulse <= swTake || hwTake;
  end

  // R5: a pulse without a software request traces back to a qualified hardware request
  p_hw_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (acceptPulse && !$past(swReq)) |->
      ($past(hwReq) && $past(ieFlag) && ($past(hwLevel) > $past(curLevel))));

  // R4: software requests are never masked
  p_sw_taken_r4: assert property (@(posedge clk) disable iff (!rstN)
    swReq |=> acceptPulse);

  // R4: no request of either kind, no pulse
  p_no_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!swReq && !hwReq) |=> !acceptPulse);
endmodule

// File: rtl/psw_datapath.sv
module psw_datapath
  import psw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strobes,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              aluOverflow,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] flagWord
);
  localparam int SIGN_POS = DATA_W - 1;

  logic [WORD_W-1:0] flagReg;
  logic [WORD_W-1:0] flagNext;
  logic              resZero;

  assign resZero = (aluResult == '0);

  always_comb begin
    flagNext = flagReg;
    if (strobes.ldAlu) begin
      flagNext[CARRY_B] = aluCarry;
      flagNext[OVF_B]   = aluOverflow;
      flagNext[ZERO_B]  = resZero;
      flagNext[SIGN_B]  = aluResult[SIGN_POS];
    end
    if (strobes.ldWord) flagNext = wrData;
    if (strobes.ackTake)  flagNext[IEN_B]   = 1'b0;
    if (strobes.clrStack) flagNext[STACK_B] = 1'b0;
    flagNext = flagNext & LIVE_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagReg <= '0;
    else       flagReg <= flagNext;
  end

  assign flagWord = flagReg;

  // R3: dead bit positions never hold a one
  p_dead_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (flagReg & ~LIVE_MASK) == '0);

  // R6: acknowledge always leaves interrupts disabled
  p_ack_clears_ien_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.ackTake) |-> !flagReg[IEN_B]);

  // R2: zero flag tracks the ALU result when no write competes
  p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.ldAlu && !strobes.ldWord) |->
      (flagReg[ZERO_B] == ($past(aluResult) == '0)));

  // R3: a write carries the written priority level through
  p_write_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.ldWord) |-> (flagReg[LVL_HI:LVL_LO] == $past(wrData[LVL_HI:LVL_LO])));
endmodule

// File: rtl/psw_irq_gate.sv
module psw_irq_gate
  import psw_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int VEC_W         = 6,
  parameter int STACK_VEC_LIM = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aluStrobe,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              aluOverflow,
  input  logic              wrEn,
  input  logic [15:0]       wrData,
  input  logic              swReq,
  input  logic [VEC_W-1:0]  swVector,
  input  logic              hwReq,
  input  logic [2:0]        hwLevel,
  output logic [15:0]       flagWord,
  output logic              acceptPulse,
  output logic              stackUser
);
  flagStrobe_t strobes;

  psw_ctrl #(
    .VEC_W(VEC_W), .LEVEL_W(LVL_W), .STACK_VEC_LIM(STACK_VEC_LIM)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .aluStrobe(aluStrobe), .wrEn(wrEn),
    .swReq(swReq), .swVector(swVector),
    .hwReq(hwReq), .hwLevel(hwLevel),
    .ieFlag(flagWord[IEN_B]), .curLevel(flagWord[LVL_HI:LVL_LO]),
    .strobes(strobes), .acceptPulse(acceptPulse)
  );

  psw_datapath #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .aluResult(aluResult), .aluCarry(aluCarry), .aluOverflow(aluOverflow),
    .wrData(wrData), .flagWord(flagWord)
  );

  assign stackUser = flagWord[STACK_B];

  // R7: a high software vector with no write leaves stack select alone
  p_high_vec_keeps_stack_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(swReq) && ({1'b0, $past(swVector)} >= (VEC_W+1)'(STACK_VEC_LIM)) && !$past(wrEn)) |->
      (flagWord[STACK_B] == $past(flagWord[STACK_B])));

  // R6 and R7: every pulse sees the enable bit already low
  p_pulse_ien_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    acceptPulse |-> !flagWord[IEN_B]);
endmodule

// File: tb/tb_psw_irq_gate.sv
`timescale 1ns/1ps
module tb_psw_irq_gate;
  logic        clk = 1'b0;
  logic        rstN;
  logic        aluStrobe, aluCarry, aluOverflow, wrEn, swReq, hwReq;
  logic [15:0] aluResult, wrData;
  logic [5:0]  swVector;
  logic [2:0]  hwLevel;
  logic [15:0] flagWord;
  logic        acceptPulse, stackUser;

  int nTests = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  psw_irq_gate dut (
    .clk(clk), .rstN(rstN), .aluStrobe(aluStrobe), .aluResult(aluResult),
    .aluCarry(aluCarry), .aluOverflow(aluOverflow), .wrEn(wrEn), .wrData(wrData),
    .swReq(swReq), .swVector(swVector), .hwReq(hwReq), .hwLevel(hwLevel),
    .flagWord(flagWord), .acceptPulse(acceptPulse), .stackUser(stackUser)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeWord(input logic [15:0] v);
    @(negedge clk); wrEn = 1'b1; wrData = v;
    @(negedge clk); wrEn = 1'b0;
  endtask

  function automatic logic [15:0] mkWord(input int lvl, input bit ien, input bit stk);
    return 16'((lvl & 7) << 12) | (ien ? 16'h0040 : 16'h0) | (stk ? 16'h0080 : 16'h0);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; aluStrobe = 0; aluCarry = 0; aluOverflow = 0; wrEn = 0; swReq = 0;
    hwReq = 0; aluResult = '0; wrData = '0; swVector = '0; hwLevel = '0;
    repeat (3) @(negedge clk);
    chk("R1 flagWord in reset", flagWord, 16'h0);
    chk("R1 acceptPulse in reset", {15'b0, acceptPulse}, 16'h0);
    chk("R1 stackUser in reset", {15'b0, stackUser}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 flagWord after reset", flagWord, 16'h0);

    // R3: dead bits stay zero, live bits load
    writeWord(16'hFFFF);
    chk("R3 full write masked", flagWord, 16'h70FF);
    chk("R9 stackUser follows bit 7", {15'b0, stackUser}, 16'h1);
    writeWord(16'h0000);

    // R5 R6 R7 R9: hardware gate sweep
    for (int ie = 0; ie < 2; ie++)
      for (int ipl = 0; ipl < 8; ipl++)
        for (int lv = 0; lv < 8; lv++) begin
          logic [15:0] base;
          bit take;
          base = mkWord(ipl, ie[0], 1'b1) | 16'h0010;
          writeWord(base);
          @(negedge clk); hwReq = 1'b1; hwLevel = 3'(lv);
          @(negedge clk); hwReq = 1'b0;
          take = (ie != 0) && (lv > ipl);
          chk("R5 hw accept", {15'b0, acceptPulse}, {15'b0, take});
          chk("R6 R7 hw flag effects", flagWord, take ? (base & ~16'h00C0) : base);
          chk("R9 stackUser", {15'b0, stackUser}, {15'b0, !take});
          @(negedge clk);
          chk("R4 pulse falls", {15'b0, acceptPulse}, 16'h0);
        end

    // R4 R5 R6 R7: software vector sweep with a competing hardware request
    for (int v = 0; v < 64; v++) begin
      logic [15:0] base;
      base = mkWord(v % 7, (v % 3) != 0, 1'b1) | 16'h0001;
      writeWord(base);
      @(negedge clk); swReq = 1'b1; swVector = 6'(v); hwReq = 1'b1; hwLevel = 3'd7;
      @(negedge clk); swReq = 1'b0; hwReq = 1'b0;
      chk("R4 sw accept", {15'b0, acceptPulse}, 16'h1);
      chk("R6 R7 sw flag effects", flagWord,
          (v < 32) ? (base & ~16'h00C0) : (base & ~16'h0040));
      @(negedge clk);
      chk("R5 single pulse when sw and hw coincide", {15'b0, acceptPulse}, 16'h0);
    end

    // R2: ALU flag updates over a spread of results
    writeWord(16'h70D2);
    for (int i = 0; i < 48; i++) begin
      logic [15:0] r, exp;
      r = (i == 0) ? 16'h0 : (i == 1) ? 16'h8000 : 16'((i * 16'h1357) ^ (i << 11));
      @(negedge clk); aluStrobe = 1'b1; aluResult = r; aluCarry = i[0]; aluOverflow = i[1];
      @(negedge clk); aluStrobe = 1'b0;
      exp = 16'h70D2 & ~16'h002D;
      exp = exp | {15'b0, i[0]} | (i[1] ? 16'h0020 : 16'h0) |
            ((r == 0) ? 16'h0004 : 16'h0) | (r[15] ? 16'h0008 : 16'h0);
      chk("R2 alu flags", flagWord, exp);
      writeWord(16'h70D2);
    end

    // R3: write beats ALU update in the same cycle
    @(negedge clk); wrEn = 1; wrData = 16'h3012; aluStrobe = 1; aluResult = 16'h0; aluCarry = 1; aluOverflow = 1;
    @(negedge clk); wrEn = 0; aluStrobe = 0;
    chk("R3 write wins over alu", flagWord, 16'h3012);

    // R8: write and acknowledge in the same cycle
    @(negedge clk); wrEn = 1; wrData = 16'h50FF; swReq = 1; swVector = 6'd5;
    @(negedge clk); wrEn = 0; swReq = 0;
    chk("R8 ack beats write, low vector", flagWord, 16'h503F);
    @(negedge clk); wrEn = 1; wrData = 16'h20C4; swReq = 1; swVector = 6'd40;
    @(negedge clk); wrEn = 0; swReq = 0;
    chk("R8 ack beats write, high vector", flagWord, 16'h2084);
    writeWord(16'h10C0);
    @(negedge clk); wrEn = 1; wrData = 16'h60C8; hwReq = 1; hwLevel = 3'd3;
    @(negedge clk); wrEn = 0; hwReq = 0;
    chk("R8 hw ack judged on old level beats write", flagWord, 16'h6008);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule